// File: doc/BRIEF.md
# Error-Tolerant DMA Burst Engine

This block is a single DMA channel that moves words between system memory, reached through an on-chip bus master port, and a peripheral FIFO. Transfers run in bursts of a parameterised number of beats. Each beat is one bus access and one FIFO access. The engine keeps two descriptor fields: a current address, which holds the start address of the next burst, and a remaining word count.

The bus slave can answer any beat with an error. The engine does not cut the burst short when that happens. It finishes every beat of the burst, records the error in one of two sticky flags (one for reads, one for writes), raises an interrupt, and then halts at the burst boundary. Software clears a flag by writing zero to its bit. A fresh start command from software clears the halted state.

Top module: `dma_burst_engine`

## Requirements
- R1: A `start` pulse is taken only while `busy` is low. It loads `cur_addr` from `start_addr` and `remain` from `start_cnt`. A count of zero leaves the engine idle. A `start` pulse while `busy` is high has no effect on the transfer in progress or on the descriptor fields.
- R2: Beat k of a burst accesses byte address `cur_addr + k*DATA_W/8`, where `cur_addr` is the start address of that burst. In memory-to-peripheral mode (`start_dir`=0) each beat is a bus read (`bus_we`=0) followed by a FIFO push. In peripheral-to-memory mode (`start_dir`=1) each beat is a FIFO pop followed by a bus write (`bus_we`=1). At most one of `bus_req`, `per_wr_en`, `per_rd_en` is high in any cycle.
- R3: A burst has min(BURST_LEN, `remain`) beats. At the end of each burst, `remain` drops by that number, and beats that carried an error are included.
- R4: A bus error on a beat does not shorten the burst. Every remaining beat of that burst is still issued.
- R5: In memory-to-peripheral mode, every beat pushes exactly one word to the FIFO, including a beat whose read returned an error. The pushed word equals the read data, and its value is undefined on an errored beat.
- R6: In peripheral-to-memory mode, every beat pops exactly one FIFO word and writes it to memory in pop order. A word whose write errored is dropped and is not retried.
- R7: After a burst with no error, `cur_addr` is the address just past the burst's last beat. After a burst with an error, `cur_addr` is the address of that burst's last beat.
- R8: A bus error on a read beat sets `rd_err`, and a bus error on a write beat sets `wr_err`. The flag is high from the cycle after the erroring handshake.
- R9: A flag stays set until a cycle with `sw_wr` high and its bit of `sw_data` at zero (bit 0 for `rd_err`, bit 1 for `wr_err`). Writing one has no effect. When a set and a clear land in the same cycle, the set wins.
- R10: `irq` is high exactly when `rd_err` or `wr_err` is high.
- R11: After a burst that contained an error, the engine goes idle with `halted` high. The next accepted `start` clears `halted`.
- R12: After reset, `busy`, `halted`, `rd_err`, `wr_err`, `irq`, `bus_req`, `per_wr_en`, `per_rd_en`, `cur_addr` and `remain` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start command for a new transfer |
| start_dir | input | 1 | 0 = memory to peripheral, 1 = peripheral to memory |
| start_addr | input | ADDR_W | Memory start byte address |
| start_cnt | input | CNT_W | Number of words to move |
| bus_req | output | 1 | Bus access request, held until `bus_ack` |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Bus slave completes the current beat |
| bus_err | input | 1 | Beat completed with an error (valid with `bus_ack`) |
| bus_rdata | input | DATA_W | Bus read data (valid with `bus_ack`) |
| per_wr_en | output | 1 | Push one word into the peripheral FIFO |
| per_wr_data | output | DATA_W | Word pushed to the peripheral |
| per_full | input | 1 | Peripheral FIFO cannot take a word |
| per_rd_en | output | 1 | Pop one word from the peripheral FIFO |
| per_rd_data | input | DATA_W | Head word of the peripheral FIFO |
| per_empty | input | 1 | Peripheral FIFO has no word |
| sw_wr | input | 1 | Software write strobe for the error flags |
| sw_data | input | 2 | Written flag values: bit 0 read flag, bit 1 write flag |
| rd_err | output | 1 | Sticky read-error flag |
| wr_err | output | 1 | Sticky write-error flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A transfer is in progress |
| halted | output | 1 | Last transfer stopped on an errored burst |
| cur_addr | output | ADDR_W | Descriptor current address |
| remain | output | CNT_W | Descriptor remaining word count |

## Verification
Several internal faults show up directly at the ports. A beat counter or burst-length fault shows up in the sequence of bus addresses and in the number of FIFO handshakes inside the same burst. It also leaves `cur_addr` and `remain` one burst step off when `busy` falls. If the engine aborts on an error instead of draining the burst, the expected addresses are left unissued and the push or pop count comes up short. A flag that is set, held or cleared in the wrong cycle is caught on the very next clock, because the bench keeps its own cycle model of both sticky bits and of the interrupt. That model includes a set and a clear landing together. A lost or repeated FIFO word appears as a data mismatch on the next bus write or push.

// File: rtl/dma_pkg.sv
// Shared types for the DMA burst engine.
package dma_pkg;

    // Engine sequencing states: one bus phase and one FIFO phase per beat.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_PER  = 2'd2,
        ST_END  = 2'd3
    } dma_state_e;

    // Transfer direction.
    typedef enum logic {
        DIR_M2P = 1'b0,
        DIR_P2M = 1'b1
    } dma_dir_e;

endpackage

// File: rtl/dma_desc_regs.sv
// Descriptor registers: current address and remaining count.
// Works out the length of the running burst and the address of each beat.
// Assumes cur_addr holds the burst start address for the whole burst, and
// that the sequencer raises burst_end for exactly one cycle per burst.
module dma_desc_regs #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int BURST_LEN  = 4,
    parameter int WORD_BYTES = 4,
    parameter int BEAT_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              burst_end,
    input  logic              burst_err,
    input  logic [BEAT_W-1:0] beat_idx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remain,
    output logic [BEAT_W-1:0] blen,
    output logic              last_burst,
    output logic [ADDR_W-1:0] beat_addr
);

    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(BURST_LEN);
    localparam logic [BEAT_W-1:0] FULL_BEAT = BEAT_W'(BURST_LEN);
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] next_clean;
    logic [ADDR_W-1:0] next_err;

    // Burst length, beat address and the two possible end-of-burst addresses.
    always_comb begin
        blen       = (remain >= FULL_CNT) ? FULL_BEAT : remain[BEAT_W-1:0];
        last_burst = (remain == CNT_W'(blen));
        beat_addr  = cur_addr + ADDR_W'(beat_idx) * STEP;
        next_clean = cur_addr + ADDR_W'(blen) * STEP;
        next_err   = cur_addr + ADDR_W'(blen - 1'b1) * STEP;
    end

    // Load on start; step address and count once at each burst end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            remain   <= ld_cnt;
        end else if (burst_end) begin
            cur_addr <= burst_err ? next_err : next_clean;
            remain   <= remain - CNT_W'(blen);
        end
    end

endmodule

// File: rtl/dma_beat_fsm.sv
// Beat sequencer. Each beat has a bus phase and a FIFO phase, in an order set
// by the direction. Errors are collected for the burst but never cut it short.
// The sequencer stops at the burst boundary when the burst saw an error.
// Assumes bus_err is only meaningful together with bus_ack.
module dma_beat_fsm
    import dma_pkg::*;
#(
    parameter int BEAT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic              cnt_zero,
    input  logic [BEAT_W-1:0] blen,
    input  logic              last_burst,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic              per_full,
    input  logic              per_empty,
    output dma_state_e        state,
    output dma_dir_e          dir,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              burst_err,
    output logic              halted,
    output logic              load,
    output logic              burst_end,
    output logic              bus_req,
    output logic              per_push,
    output logic              per_pop
);

    dma_state_e first_phase;
    logic       beat_done;
    logic       last_beat;

    // Handshake strobes and beat bookkeeping decoded from the state.
    always_comb begin
        first_phase = (dir == DIR_M2P) ? ST_BUS : ST_PER;
        bus_req     = (state == ST_BUS);
        per_push    = (state == ST_PER) && (dir == DIR_M2P) && !per_full;
        per_pop     = (state == ST_PER) && (dir == DIR_P2M) && !per_empty;
        beat_done   = (bus_req && bus_ack && dir == DIR_P2M) || per_push;
        last_beat   = (beat_idx == blen - 1'b1);
        load        = (state == ST_IDLE) && start;
        burst_end   = (state == ST_END);
    end

    // State, beat index, burst error collection and halt tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dir       <= DIR_M2P;
            beat_idx  <= '0;
            burst_err <= 1'b0;
            halted    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        dir       <= dma_dir_e'(start_dir);
                        halted    <= 1'b0;
                        beat_idx  <= '0;
                        burst_err <= 1'b0;
                        if (!cnt_zero) begin
                            state <= start_dir ? ST_PER : ST_BUS;
                        end
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        if (bus_err) begin
                            burst_err <= 1'b1;
                        end
                        if (dir == DIR_M2P) begin
                            state <= ST_PER;
                        end else if (last_beat) begin
                            state <= ST_END;
                        end else begin
                            beat_idx <= beat_idx + 1'b1;
                            state    <= first_phase;
                        end
                    end
                end
                ST_PER: begin
                    if (per_pop) begin
                        state <= ST_BUS;
                    end else if (beat_done) begin
                        if (last_beat) begin
                            state <= ST_END;
                        end else begin
                            beat_idx <= beat_idx + 1'b1;
                            state    <= first_phase;
                        end
                    end
                end
                ST_END: begin
                    if (burst_err) begin
                        halted <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (last_burst) begin
                        state <= ST_IDLE;
                    end else begin
                        beat_idx  <= '0;
                        burst_err <= 1'b0;
                        state     <= first_phase;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_err_log.sv
// Sticky error flags, one per access kind, and the interrupt they drive.
// Bit 0 is the read flag and bit 1 the write flag. Software clears a flag by
// writing zero to its bit. A set in the same cycle takes priority.
module dma_err_log #(
    parameter int NFLAGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_vec,
    input  logic              sw_wr,
    input  logic [NFLAGS-1:0] sw_data,
    output logic [NFLAGS-1:0] flags,
    output logic              irq
);

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        logic bit_q;

        // One sticky bit: set by hardware, cleared by a zero write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_vec[i]) begin
                bit_q <= 1'b1;
            end else if (sw_wr && !sw_data[i]) begin
                bit_q <= 1'b0;
            end
        end

        assign flags[i] = bit_q;
    end

    // Interrupt is raised while any flag is set.
    assign irq = |flags;

endmodule

// File: rtl/dma_burst_engine.sv
// DMA burst engine top. Moves words between the bus and a peripheral FIFO
// in bursts of BURST_LEN beats and tolerates slave errors without cutting a
// burst short. Assumes the bus slave holds bus_rdata valid with bus_ack and
// that the FIFO's head word is visible on per_rd_data while per_empty is low.
module dma_burst_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_cnt,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              per_wr_en,
    output logic [DATA_W-1:0] per_wr_data,
    input  logic              per_full,
    output logic              per_rd_en,
    input  logic [DATA_W-1:0] per_rd_data,
    input  logic              per_empty,
    input  logic              sw_wr,
    input  logic [1:0]        sw_data,
    output logic              rd_err,
    output logic              wr_err,
    output logic              irq,
    output logic              busy,
    output logic              halted,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  remain
);

    localparam int WORD_BYTES = DATA_W / 8;
    localparam int BEAT_W     = $clog2(BURST_LEN + 1);

    dma_state_e        state;
    dma_dir_e          dir;
    logic [BEAT_W-1:0] beat_idx;
    logic [BEAT_W-1:0] blen;
    logic              last_burst;
    logic              burst_err;
    logic              load;
    logic              burst_end;
    logic [DATA_W-1:0] hold_q;
    logic [1:0]        err_set;
    logic [1:0]        err_flags;

    dma_beat_fsm #(
        .BEAT_W(BEAT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_dir (start_dir),
        .cnt_zero  (start_cnt == '0),
        .blen      (blen),
        .last_burst(last_burst),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .per_full  (per_full),
        .per_empty (per_empty),
        .state     (state),
        .dir       (dir),
        .beat_idx  (beat_idx),
        .burst_err (burst_err),
        .halted    (halted),
        .load      (load),
        .burst_end (burst_end),
        .bus_req   (bus_req),
        .per_push  (per_wr_en),
        .per_pop   (per_rd_en)
    );

    dma_desc_regs #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .BURST_LEN (BURST_LEN),
        .WORD_BYTES(WORD_BYTES),
        .BEAT_W    (BEAT_W)
    ) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_addr   (start_addr),
        .ld_cnt    (start_cnt),
        .burst_end (burst_end),
        .burst_err (burst_err),
        .beat_idx  (beat_idx),
        .cur_addr  (cur_addr),
        .remain    (remain),
        .blen      (blen),
        .last_burst(last_burst),
        .beat_addr (bus_addr)
    );

    // Error flag set strobes: bit 0 on an errored read, bit 1 on an errored write.
    always_comb begin
        err_set[0] = bus_req && bus_ack && bus_err && !bus_we;
        err_set[1] = bus_req && bus_ack && bus_err &&  bus_we;
    end

    dma_err_log #(
        .NFLAGS(2)
    ) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(err_set),
        .sw_wr  (sw_wr),
        .sw_data(sw_data),
        .flags  (err_flags),
        .irq    (irq)
    );

    // Word in flight: read data on a read beat, FIFO head on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (bus_req && bus_ack && !bus_we) begin
            hold_q <= bus_rdata;
        end else if (per_rd_en) begin
            hold_q <= per_rd_data;
        end
    end

    // Port-facing decodes.
    assign bus_we      = (dir == DIR_P2M);
    assign bus_wdata   = hold_q;
    assign per_wr_data = hold_q;
    assign busy        = (state != ST_IDLE);
    assign rd_err      = err_flags[0];
    assign wr_err      = err_flags[1];

endmodule

// File: rtl/dma_burst_checker.sv
// Protocol and flag properties for the DMA burst engine, bound to its top.
module dma_burst_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              per_wr_en,
    input logic              per_rd_en,
    input logic [1:0]        sw_data,
    input logic              sw_wr,
    input logic              rd_err,
    input logic              wr_err,
    input logic              busy,
    input logic              halted,
    input logic [CNT_W-1:0]  remain
);

    // R2
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req, per_wr_en, per_rd_en}));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr));

    // R8
    rd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err && !bus_we |=> rd_err);

    // R8
    wr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && bus_err && bus_we |=> wr_err);

    // R9
    rd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err && !(sw_wr && !sw_data[0]) |=> rd_err);

    // R9
    wr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err && !(sw_wr && !sw_data[1]) |=> wr_err);

    // R11
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !busy);

    // R3
    remain_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> remain <= $past(remain));

endmodule

bind dma_burst_engine dma_burst_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .per_wr_en(per_wr_en),
    .per_rd_en(per_rd_en),
    .sw_data  (sw_data),
    .sw_wr    (sw_wr),
    .rd_err   (rd_err),
    .wr_err   (wr_err),
    .busy     (busy),
    .halted   (halted),
    .remain   (remain)
);

// File: tb/tb_dma_burst_engine.sv
// Bench for the DMA burst engine: behavioural bus slave, FIFO and flag model.
module tb_dma_burst_engine;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int BL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          start_dir = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] start_cnt = '0;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic          bus_err = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          per_wr_en, per_rd_en;
    logic [DW-1:0] per_wr_data;
    logic          per_full = 1'b0;
    logic          per_empty = 1'b0;
    logic [DW-1:0] per_rd_data = '0;
    logic          sw_wr = 1'b0;
    logic [1:0]    sw_data = 2'b11;
    logic          rd_err, wr_err, irq, busy, halted;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] remain;

    always #5 clk = ~clk;

    dma_burst_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .BURST_LEN(BL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
        .start_addr(start_addr), .start_cnt(start_cnt),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .per_wr_en(per_wr_en), .per_wr_data(per_wr_data), .per_full(per_full),
        .per_rd_en(per_rd_en), .per_rd_data(per_rd_data), .per_empty(per_empty),
        .sw_wr(sw_wr), .sw_data(sw_data), .rd_err(rd_err), .wr_err(wr_err), .irq(irq),
        .busy(busy), .halted(halted), .cur_addr(cur_addr), .remain(remain)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Environment state and reference model.
    bit            live = 1'b0;
    bit            stall_en = 1'b0;
    int            slave_wait = 0;
    int            wait_left = 0;
    bit            err_en = 1'b0;
    logic [AW-1:0] err_addr = '0;
    int            cyc = 0;
    int            n_push = 0;
    int            n_pop = 0;
    logic [DW-1:0] pop_val = 32'h0000_0100;
    bit            m_rd = 1'b0;
    bit            m_wr = 1'b0;
    logic [AW-1:0] exp_addr_q[$];
    logic [DW:0]   push_q[$];
    logic [DW-1:0] pop_q[$];

    // Every falling edge: compare flags with the model, drive the slave and
    // FIFO, then log the handshakes that complete at the next rising edge.
    always @(negedge clk) begin
        logic       set_r, set_w;
        logic [AW-1:0] e;
        logic [DW-1:0] d;
        logic [DW:0]   p;
        cyc++;
        if (live && !done) begin
            chk(rd_err === m_rd, "R8", "rd_err vs model", rd_err, m_rd);
            chk(wr_err === m_wr, "R9", "wr_err vs model", wr_err, m_wr);
            chk(irq === (m_rd | m_wr), "R10", "irq vs model", irq, m_rd | m_wr);
        end
        per_full    = stall_en && (cyc % 3 == 0);
        per_empty   = stall_en && (cyc % 4 == 1);
        per_rd_data = pop_val;
        if (bus_req) begin
            if (wait_left == 0) begin
                bus_ack   = 1'b1;
                bus_err   = err_en && (bus_addr == err_addr);
                bus_rdata = bus_addr ^ 32'h5A5A_0000;
            end else begin
                bus_ack = 1'b0;
                bus_err = 1'b0;
                wait_left--;
            end
        end else begin
            bus_ack   = 1'b0;
            bus_err   = 1'b0;
            wait_left = slave_wait;
        end
        #1;
        if (!rst_n) begin
            m_rd = 1'b0;
            m_wr = 1'b0;
        end else begin
            set_r = bus_req && bus_ack && bus_err && !bus_we;
            set_w = bus_req && bus_ack && bus_err && bus_we;
            if (bus_req && bus_ack) begin
                if (exp_addr_q.size() == 0) begin
                    chk(1'b0, "R4", "beat beyond burst", bus_addr, 0);
                end else begin
                    e = exp_addr_q.pop_front();
                    chk(bus_addr == e, "R2", "beat address", bus_addr, e);
                end
                if (bus_we) begin
                    if (pop_q.size() == 0) begin
                        chk(1'b0, "R6", "write without pop", bus_wdata, 0);
                    end else begin
                        d = pop_q.pop_front();
                        chk(bus_wdata == d, "R6", "written word", bus_wdata, d);
                    end
                end else begin
                    push_q.push_back({bus_err, bus_rdata});
                end
            end
            if (per_wr_en) begin
                n_push++;
                if (push_q.size() == 0) begin
                    chk(1'b0, "R5", "push without read", per_wr_data, 0);
                end else begin
                    p = push_q.pop_front();
                    if (!p[DW]) begin
                        chk(per_wr_data == p[DW-1:0], "R5", "pushed word", per_wr_data, p[DW-1:0]);
                    end
                end
            end
            if (per_rd_en) begin
                n_pop++;
                pop_q.push_back(per_rd_data);
                pop_val++;
            end
            m_rd = set_r ? 1'b1 : (sw_wr && !sw_data[0]) ? 1'b0 : m_rd;
            m_wr = set_w ? 1'b1 : (sw_wr && !sw_data[1]) ? 1'b0 : m_wr;
        end
    end

    // One transfer: predict beats and final descriptor, run, then compare.
    task automatic run(input bit d, input logic [AW-1:0] a, input int cnt,
                       input bit e_en, input logic [AW-1:0] e_addr, input bit poke);
        logic [AW-1:0] xa = a;
        int xr = cnt;
        int beats = 0;
        bit xhalt = 1'b0;
        while (xr > 0) begin
            int  bl = (xr >= BL) ? BL : xr;
            bit  hit = 1'b0;
            for (int k = 0; k < bl; k++) begin
                exp_addr_q.push_back(xa + AW'(4 * k));
                if (e_en && (xa + AW'(4 * k) == e_addr)) hit = 1'b1;
            end
            beats += bl;
            xr    -= bl;
            if (hit) begin
                xa    = xa + AW'(4 * (bl - 1));
                xhalt = 1'b1;
                break;
            end
            xa = xa + AW'(4 * bl);
        end
        err_en   = e_en;
        err_addr = e_addr;
        n_push   = 0;
        n_pop    = 0;
        @(negedge clk);
        start = 1'b1; start_dir = d; start_addr = a; start_cnt = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
        if (cnt > 0) begin
            chk(busy == 1'b1, "R1", "busy after start", busy, 1);
            chk(halted == 1'b0, "R11", "halted cleared by start", halted, 0);
        end else begin
            chk(busy == 1'b0, "R1", "zero count stays idle", busy, 0);
        end
        if (poke) begin
            @(negedge clk);
            start = 1'b1; start_dir = ~d; start_addr = 32'hDEAD_0000; start_cnt = 3;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(cur_addr == xa, "R7", "final cur_addr", cur_addr, xa);
        chk(remain == CW'(xr), "R3", "final remain", remain, xr);
        chk(halted == xhalt, "R11", "halted", halted, xhalt);
        chk(exp_addr_q.size() == 0, "R4", "beats left unissued", exp_addr_q.size(), 0);
        chk(n_push == (d ? 0 : beats), "R5", "push count", n_push, d ? 0 : beats);
        chk(n_pop == (d ? beats : 0), "R6", "pop count", n_pop, d ? beats : 0);
        exp_addr_q.delete();
        push_q.delete();
        pop_q.delete();
        err_en = 1'b0;
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: actual busy %0d expected idle", busy);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 0 && halted == 0, "R12", "busy/halted at reset", {busy, halted}, 0);
        chk(bus_req == 0 && per_wr_en == 0 && per_rd_en == 0, "R12", "strobes at reset",
            {bus_req, per_wr_en, per_rd_en}, 0);
        chk(rd_err == 0 && wr_err == 0 && irq == 0, "R12", "flags at reset", {rd_err, wr_err, irq}, 0);
        chk(cur_addr == 0 && remain == 0, "R12", "descriptor at reset", {cur_addr, remain}, 0);
        rst_n = 1'b1;
        live  = 1'b1;

        // R2 R3 R7: clean two-burst read transfer
        run(1'b0, 32'h0000_1000, 8, 1'b0, '0, 1'b0);

        // R3 R6: write transfer with a short tail burst, stalls and slave waits
        stall_en = 1'b1; slave_wait = 1;
        run(1'b1, 32'h0000_2000, 6, 1'b0, '0, 1'b0);

        // R4 R5 R7 R8 R11: read error on beat 1 of the second burst
        slave_wait = 0;
        run(1'b0, 32'h0000_3000, 12, 1'b1, 32'h0000_3014, 1'b0);
        chk(rd_err == 1 && irq == 1, "R8", "read flag after errored read", {rd_err, irq}, 2'b11);

        // R9: writing ones leaves the flag; writing zero to bit 0 clears it
        @(negedge clk); sw_wr = 1'b1; sw_data = 2'b11;
        @(negedge clk); sw_wr = 1'b0;
        chk(rd_err == 1'b1, "R9", "write of one keeps flag", rd_err, 1);
        sw_wr = 1'b1; sw_data = 2'b10;
        @(negedge clk); sw_wr = 1'b0; sw_data = 2'b11;
        chk(rd_err == 1'b0 && irq == 1'b0, "R9", "zero write clears flag", {rd_err, irq}, 0);

        // R1 R9 R11: start while busy ignored; set beats a held clear, then clears
        sw_wr = 1'b1; sw_data = 2'b00;
        run(1'b1, 32'h0000_4000, 4, 1'b1, 32'h0000_400C, 1'b1);
        sw_wr = 1'b0; sw_data = 2'b11;
        @(negedge clk);
        chk(wr_err == 1'b0, "R9", "held clear removes flag after set", wr_err, 0);

        // R6 R7 R8: write error on the first beat, burst still drained
        stall_en = 1'b0;
        run(1'b1, 32'h0000_5000, 8, 1'b1, 32'h0000_5000, 1'b0);
        chk(wr_err == 1'b1 && irq == 1'b1, "R8", "write flag after errored write", {wr_err, irq}, 2'b11);

        // R1 R11: zero count loads the descriptor and stays idle
        run(1'b0, 32'h0000_6000, 0, 1'b0, '0, 1'b0);
        chk(halted == 1'b0, "R11", "halted cleared by zero-count start", halted, 0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule